// File: doc/BRIEF.md
# Bus Breakpoint Comparator

This block snoops every cycle on a CPU's internal bus. When a cycle meets the conditions that software has programmed, it raises a break interrupt request. The conditions are a cycle kind, an address compared only in its upper bits, and a data pattern compared on selected byte lanes. Software programs three registers through a simple write port: an 8-bit control register, a 16-bit breakpoint address and a 16-bit breakpoint data value. A sticky break flag holds each match until software clears it.

The block also holds the interrupt hold-off that follows a return-from-exception. If the control register's return-enable bit is clear, the break request is gated off from the end of the return until the next instruction completes.

The bus side is a passive monitor. It reads `bus_valid` as a qualifier, has no ready signal and never applies back-pressure. Each cycle with `bus_valid` high is evaluated exactly once. A word access to an 8-bit I/O region reaches the block as two separate byte cycles, and each of the two is judged on its own.

Top module: `brk_cmp_top`

## Requirements
- R1: After reset the control register reads 0x80, meaning the return-enable bit is 1 and every other bit is 0. The address and data registers read 0, and `brk_flag` and `brk_irq` are both 0.
- R2: The cycle condition is control bits 6:5. Code 00 matches execute cycles, 01 matches data reads, 10 matches data writes and 11 matches both reads and writes. The `bus_kind` encodings are 00 execute, 01 read, 10 write and 11 idle.
- R3: The address mode is control bits 4:2. Code 000 compares all 16 bits, 001 compares bits 15:4, 010 compares bits 15:8 and 011 compares bits 15:12.
- R4: An address mode with bit 4 set (codes 1xx) never produces a match.
- R5: The data mode is control bits 1:0. Code 00 applies no data check, 01 compares data bits 7:0, 10 compares bits 15:8 and 11 compares all 16 bits.
- R6: A byte access (`bus_word`=0) at an even address drives only lane 15:8, and at an odd address only lane 7:0. A data mode that needs a lane the access does not drive never matches.
- R7: A match needs `bus_valid`=1, the right cycle kind, an equal masked address and equal selected data lanes, all in the same cycle. It shows on `brk_flag` after the next rising edge.
- R8: `brk_flag` is sticky. Writing register select 3 with bit 0 = 0 clears it, and writing bit 0 = 1 has no effect. A match in the same cycle as a clear leaves the flag set.
- R9: When no return hold-off is active, `brk_irq` equals `brk_flag`.
- R10: A `rte_done` pulse while the return-enable bit (control bit 7) is 0 holds `brk_irq` at 0 until an `insn_done` pulse.
- R11: A `rte_done` pulse while the return-enable bit is 1 causes no hold-off.
- R12: The register selects are 0 for control (bits 7:0 of the write data; bits 15:8 ignored), 1 for address, 2 for data and 3 for status (flag in bit 0). `reg_rdata` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register value |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_kind | input | 2 | Cycle kind: execute, read, write, idle |
| bus_addr | input | 16 | Bus address |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_data | input | 16 | Bus data, byte placed on its lane |
| rte_done | input | 1 | Return-from-exception completed |
| insn_done | input | 1 | Instruction completed |
| brk_flag | output | 1 | Sticky break flag |
| brk_irq | output | 1 | Break interrupt request |

## Verification
The hardest condition to reach is a break match that lands while the return hold-off is active, because the request must then stay low even though the flag is set. The bench first clears the return-enable bit and pulses `rte_done`. It then drives a matching cycle, checks that the flag is set while the request stays low, and releases the hold-off with `insn_done`. The byte-lane rules get similar treatment: a word transfer is split into two byte cycles, and the match must appear on the second cycle only.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;

  localparam logic [1:0] KIND_EXEC  = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;
  localparam logic [1:0] KIND_IDLE  = 2'b11;

  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_ADDR = 2'd1;
  localparam logic [1:0] RSEL_DATA = 2'd2;
  localparam logic [1:0] RSEL_STAT = 2'd3;

  typedef struct packed {
    logic       rte_en;
    logic [1:0] cond;
    logic [2:0] amode;
    logic [1:0] dmode;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h80;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          hit,
  output ctrl_t         ctrl,
  output logic [AW-1:0] bar,
  output logic [DW-1:0] bdr,
  output logic          flag,
  output logic [DW-1:0] rdata
);
  logic clr_wr;
  assign clr_wr = wr_en && (sel == RSEL_STAT) && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= ctrl_t'(CTRL_RST);
      bar  <= '0;
      bdr  <= '0;
    end else if (wr_en) begin
      case (sel)
        RSEL_CTRL: ctrl <= ctrl_t'(wdata[7:0]);
        RSEL_ADDR: bar  <= wdata[AW-1:0];
        RSEL_DATA: bdr  <= wdata;
        default: ;
      endcase
    end
  end

  // set has priority over a software clear
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (hit)    flag <= 1'b1;
    else if (clr_wr) flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (sel)
      RSEL_CTRL: rdata[7:0]    = ctrl;
      RSEL_ADDR: rdata[AW-1:0] = bar;
      RSEL_DATA: rdata         = bdr;
      default:   rdata[0]      = flag;
    endcase
  end

  p_hit_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int LW = LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] bar,
  input  logic [DW-1:0] bdr,
  input  logic          bus_valid,
  input  logic [1:0]    bus_kind,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_word,
  input  logic [DW-1:0] bus_data,
  output logic          hit
);
  localparam int NIB = AW / 4;

  logic           kind_ok, addr_ok, data_ok;
  logic [NIB-1:0] nib_ok;
  logic           hi_drv, lo_drv, hi_eq, lo_eq;

  always_comb begin
    case (ctrl.cond)
      2'b00:   kind_ok = (bus_kind == KIND_EXEC);
      2'b01:   kind_ok = (bus_kind == KIND_READ);
      2'b10:   kind_ok = (bus_kind == KIND_WRITE);
      default: kind_ok = (bus_kind == KIND_READ) || (bus_kind == KIND_WRITE);
    endcase
  end

  // nibble g is ignored when it lies below the mode's cut
  for (genvar g = 0; g < NIB; g++) begin : g_nib
    assign nib_ok[g] = (32'(g) < 32'(ctrl.amode)) ||
                       (bus_addr[4*g +: 4] == bar[4*g +: 4]);
  end
  assign addr_ok = !ctrl.amode[2] && (&nib_ok);

  assign hi_drv = bus_word || !bus_addr[0];
  assign lo_drv = bus_word ||  bus_addr[0];
  assign hi_eq  = (bus_data[DW-1 -: LW] == bdr[DW-1 -: LW]);
  assign lo_eq  = (bus_data[LW-1:0] == bdr[LW-1:0]);

  always_comb begin
    case (ctrl.dmode)
      2'b00:   data_ok = 1'b1;
      2'b01:   data_ok = lo_drv && lo_eq;
      2'b10:   data_ok = hi_drv && hi_eq;
      default: data_ok = hi_drv && lo_drv && hi_eq && lo_eq;
    endcase
  end

  assign hit = bus_valid && kind_ok && addr_ok && data_ok;

  p_reserved_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.amode[2] |-> !hit);
  p_byte_full_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_word && ctrl.dmode == 2'b11) |-> !hit);
  p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kind == KIND_IDLE || !bus_valid) |-> !hit);
endmodule

// File: rtl/brk_rte_mask.sv
module brk_rte_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic rte_en,
  input  logic rte_done,
  input  logic insn_done,
  output logic mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   mask <= 1'b0;
    else if (rte_done && !rte_en) mask <= 1'b1;
    else if (insn_done)           mask <= 1'b0;
  end

  p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_done && !rte_en) |=> mask);
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !insn_done) |=> mask);
  p_no_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask && rte_en) |=> !mask);
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic [1:0]    bus_kind,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_word,
  input  logic [DW-1:0] bus_data,
  input  logic          rte_done,
  input  logic          insn_done,
  output logic          brk_flag,
  output logic          brk_irq
);
  ctrl_t         ctrl;
  logic [AW-1:0] bar;
  logic [DW-1:0] bdr;
  logic          hit, mask;

  brk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .hit(hit), .ctrl(ctrl), .bar(bar), .bdr(bdr),
    .flag(brk_flag), .rdata(reg_rdata)
  );

  brk_match #(.AW(AW), .DW(DW), .LW(DW/2)) u_match (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .bar(bar), .bdr(bdr),
    .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_addr(bus_addr),
    .bus_word(bus_word), .bus_data(bus_data), .hit(hit)
  );

  brk_rte_mask u_mask (
    .clk(clk), .rst_n(rst_n), .rte_en(ctrl.rte_en),
    .rte_done(rte_done), .insn_done(insn_done), .mask(mask)
  );

  assign brk_irq = brk_flag && !mask;

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> brk_flag);
endmodule

// File: tb/brk_cmp_top_tb_top.sv
module brk_cmp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_kind = 2'b11;
  logic [15:0] bus_addr = '0;
  logic        bus_word = 1'b1;
  logic [15:0] bus_data = '0;
  logic        rte_done = 1'b0;
  logic        insn_done = 1'b0;
  logic        brk_flag, brk_irq;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] K_EX = 2'b00, K_RD = 2'b01, K_WR = 2'b10, K_ID = 2'b11;

  always #5 clk = ~clk;

  brk_cmp_top dut_i (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] s, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic cyc(logic [1:0] k, logic [15:0] a, logic w, logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = k; bus_addr = a; bus_word = w; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_kind = K_ID;
  endtask

  function automatic logic [15:0] mk(logic en, logic [1:0] c, logic [2:0] am, logic [1:0] dm);
    return {8'h00, en, c, am, dm};
  endfunction

  // one bus cycle, check flag, then clear it
  task automatic try(string req, logic [1:0] k, logic [15:0] a, logic w, logic [15:0] d, logic exp);
    cyc(k, a, w, d);
    chk(req, {15'b0, brk_flag}, {15'b0, exp});
    reg_write(2'd3, 16'h0000);
  endtask

  task automatic setup(logic [15:0] c, logic [15:0] a, logic [15:0] d);
    reg_write(2'd0, c);
    reg_write(2'd1, a);
    reg_write(2'd2, d);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_read(2'd0, v); chk("R1 ctrl", v, 16'h0080);
    reg_read(2'd1, v); chk("R1 addr", v, 16'h0000);
    reg_read(2'd2, v); chk("R1 data", v, 16'h0000);
    chk("R1 flag", {15'b0, brk_flag}, 16'h0);
    chk("R1 irq", {15'b0, brk_irq}, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    reg_write(2'd0, 16'hAB55); reg_read(2'd0, v); chk("R12 ctrl low byte", v, 16'h0055);
    reg_write(2'd1, 16'h1234); reg_read(2'd1, v); chk("R12 addr", v, 16'h1234);
    reg_write(2'd2, 16'hBEEF); reg_read(2'd2, v); chk("R12 data", v, 16'hBEEF);
  endtask

  task automatic t_cycle();
    setup(mk(1, 2'b00, 3'd0, 2'd0), 16'h4000, 16'h0);
    try("R2 exec", K_EX, 16'h4000, 1, 0, 1);
    try("R2 exec vs read", K_RD, 16'h4000, 1, 0, 0);
    setup(mk(1, 2'b01, 3'd0, 2'd0), 16'h4000, 16'h0);
    try("R2 read", K_RD, 16'h4000, 1, 0, 1);
    try("R2 read vs write", K_WR, 16'h4000, 1, 0, 0);
    setup(mk(1, 2'b10, 3'd0, 2'd0), 16'h4000, 16'h0);
    try("R2 write", K_WR, 16'h4000, 1, 0, 1);
    try("R2 write vs exec", K_EX, 16'h4000, 1, 0, 0);
    setup(mk(1, 2'b11, 3'd0, 2'd0), 16'h4000, 16'h0);
    try("R2 rw read", K_RD, 16'h4000, 1, 0, 1);
    try("R2 rw write", K_WR, 16'h4000, 1, 0, 1);
    try("R2 rw exec", K_EX, 16'h4000, 1, 0, 0);
  endtask

  task automatic t_addr();
    setup(mk(1, 2'b01, 3'd0, 2'd0), 16'hA5C3, 16'h0);
    try("R3 full hit", K_RD, 16'hA5C3, 1, 0, 1);
    try("R3 full miss", K_RD, 16'hA5C2, 1, 0, 0);
    reg_write(2'd0, mk(1, 2'b01, 3'd1, 2'd0));
    try("R3 12b hit", K_RD, 16'hA5CF, 1, 0, 1);
    try("R3 12b miss", K_RD, 16'hA5D3, 1, 0, 0);
    reg_write(2'd0, mk(1, 2'b01, 3'd2, 2'd0));
    try("R3 8b hit", K_RD, 16'hA5FF, 1, 0, 1);
    try("R3 8b miss", K_RD, 16'hA4C3, 1, 0, 0);
    reg_write(2'd0, mk(1, 2'b01, 3'd3, 2'd0));
    try("R3 4b hit", K_RD, 16'hAFFF, 1, 0, 1);
    try("R3 4b miss", K_RD, 16'hB5C3, 1, 0, 0);
  endtask

  task automatic t_reserved();
    for (int m = 4; m < 8; m++) begin
      reg_write(2'd0, mk(1, 2'b01, 3'(m), 2'd0));
      try("R4 reserved", K_RD, 16'hA5C3, 1, 0, 0);
    end
  endtask

  task automatic t_data_word();
    setup(mk(1, 2'b10, 3'd0, 2'd0), 16'h2000, 16'h12AB);
    try("R5 no data cmp", K_WR, 16'h2000, 1, 16'h5555, 1);
    reg_write(2'd0, mk(1, 2'b10, 3'd0, 2'd1));
    try("R5 low hit", K_WR, 16'h2000, 1, 16'hFFAB, 1);
    try("R5 low miss", K_WR, 16'h2000, 1, 16'h12AC, 0);
    reg_write(2'd0, mk(1, 2'b10, 3'd0, 2'd2));
    try("R5 high hit", K_WR, 16'h2000, 1, 16'h1200, 1);
    try("R5 high miss", K_WR, 16'h2000, 1, 16'h13AB, 0);
    reg_write(2'd0, mk(1, 2'b10, 3'd0, 2'd3));
    try("R5 full hit", K_WR, 16'h2000, 1, 16'h12AB, 1);
    try("R5 full miss", K_WR, 16'h2000, 1, 16'h12AA, 0);
  endtask

  task automatic t_byte();
    setup(mk(1, 2'b10, 3'd1, 2'd2), 16'h2000, 16'h12AB);
    try("R6 even high hit", K_WR, 16'h2000, 0, 16'h1200, 1);
    try("R6 odd high miss", K_WR, 16'h2001, 0, 16'h12AB, 0);
    reg_write(2'd0, mk(1, 2'b10, 3'd1, 2'd1));
    try("R6 odd low hit", K_WR, 16'h2001, 0, 16'h00AB, 1);
    try("R6 even low miss", K_WR, 16'h2000, 0, 16'h12AB, 0);
    reg_write(2'd0, mk(1, 2'b10, 3'd1, 2'd3));
    try("R6 byte full miss", K_WR, 16'h2000, 0, 16'h12AB, 0);
    // split word transfer to an 8-bit region: match only on odd half
    reg_write(2'd0, mk(1, 2'b10, 3'd1, 2'd1));
    cyc(K_WR, 16'h2000, 0, 16'hAB00);
    chk("R6 split first half", {15'b0, brk_flag}, 16'h0);
    cyc(K_WR, 16'h2001, 0, 16'h00AB);
    chk("R6 split second half", {15'b0, brk_flag}, 16'h1);
    reg_write(2'd3, 16'h0);
  endtask

  task automatic t_valid();
    setup(mk(1, 2'b01, 3'd0, 2'd3), 16'h3000, 16'h5A5A);
    @(negedge clk);
    bus_valid = 1'b0; bus_kind = K_RD; bus_addr = 16'h3000; bus_word = 1; bus_data = 16'h5A5A;
    @(negedge clk);
    bus_kind = K_ID;
    chk("R7 no valid", {15'b0, brk_flag}, 16'h0);
    try("R7 idle kind", K_ID, 16'h3000, 1, 16'h5A5A, 0);
    try("R7 addr off", K_RD, 16'h3002, 1, 16'h5A5A, 0);
    try("R7 all ok", K_RD, 16'h3000, 1, 16'h5A5A, 1);
  endtask

  task automatic t_flag();
    setup(mk(1, 2'b01, 3'd0, 2'd0), 16'h1000, 16'h0);
    cyc(K_RD, 16'h1000, 1, 0);
    chk("R9 irq follows flag", {15'b0, brk_irq}, 16'h1);
    reg_write(2'd3, 16'h0001);
    chk("R8 write 1 keeps", {15'b0, brk_flag}, 16'h1);
    @(negedge clk);
    chk("R8 sticky", {15'b0, brk_flag}, 16'h1);
    reg_write(2'd3, 16'h0000);
    chk("R8 clear", {15'b0, brk_flag}, 16'h0);
    chk("R9 irq cleared", {15'b0, brk_irq}, 16'h0);
    // match and clear in the same cycle
    @(negedge clk);
    reg_wr = 1; reg_sel = 2'd3; reg_wdata = 16'h0;
    bus_valid = 1; bus_kind = K_RD; bus_addr = 16'h1000; bus_word = 1;
    @(negedge clk);
    reg_wr = 0; bus_valid = 0; bus_kind = K_ID;
    chk("R8 set beats clear", {15'b0, brk_flag}, 16'h1);
    reg_write(2'd3, 16'h0);
  endtask

  task automatic t_mask();
    setup(mk(0, 2'b01, 3'd0, 2'd0), 16'h1000, 16'h0);
    @(negedge clk); rte_done = 1;
    @(negedge clk); rte_done = 0;
    cyc(K_RD, 16'h1000, 1, 0);
    chk("R10 flag set under mask", {15'b0, brk_flag}, 16'h1);
    chk("R10 irq held", {15'b0, brk_irq}, 16'h0);
    @(negedge clk);
    chk("R10 irq still held", {15'b0, brk_irq}, 16'h0);
    @(negedge clk); insn_done = 1;
    @(negedge clk); insn_done = 0;
    chk("R10 irq released", {15'b0, brk_irq}, 16'h1);
    reg_write(2'd3, 16'h0);
  endtask

  task automatic t_nomask();
    setup(mk(1, 2'b01, 3'd0, 2'd0), 16'h1000, 16'h0);
    @(negedge clk); rte_done = 1;
    @(negedge clk); rte_done = 0;
    cyc(K_RD, 16'h1000, 1, 0);
    chk("R11 irq not masked", {15'b0, brk_irq}, 16'h1);
    reg_write(2'd3, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_cycle();
    t_addr();
    t_reserved();
    t_data_word();
    t_byte();
    t_valid();
    t_flag();
    t_mask();
    t_nomask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule